// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block is the digital state machine of a single-wire vehicle bus transceiver. It takes the digital results of the supply comparators, the enable and transmit-data pins, and filtered wake events from a separate wake detector. From these it picks one of four modes: off, fail-safe, normal or sleep. It drives the regulator-enable (inhibit) switch, the bus termination, the communication path, and two wake-report overrides on the receive and transmit pins.

A shared 1 µs tick sets the time base. The enable pin has its own debounce filter, with separate delays for the rising and falling directions. The inhibit output stays off for a set number of ticks after power-up. A wake from sleep is shown to the host as a low receive pin. A local wake also turns on the strong pull-down on the transmit pin, so the host can tell a local wake from a remote one. Both reports drop as soon as the host drives enable high.

Top module: `xmc_mode_ctrl`

## Requirements
- R1: While `supply_good` is low, `mode` is 2'b00 (off) and `inh_on`, `term_on`, `comm_on`, `rxd_wake_low` and `txd_strong_pd` are all 0.
- R2: On the first clock with `supply_good` high, the mode leaves off and becomes 2'b01 (fail-safe). Termination is on, communication is off, and no wake report is shown.
- R3: `inh_on` is 1 only in fail-safe or normal mode, only when `supply_low` is 0, and only after `PWRUP_US` ticks have passed (counted while not off and not undervoltage) since the mode left off.
- R4: In fail-safe mode, enable held high for `EN_ON_US` consecutive ticks with `supply_low` low gives normal mode (2'b10) one clock later. `comm_on` is 1 only in normal mode.
- R5: If the enable pin returns to its filtered level before the delay completes, the filter count restarts from zero.
- R6: In normal mode, enable held low for `EN_OFF_US` consecutive ticks while `txd_in` is high gives sleep mode (2'b11). In sleep mode inhibit, termination and communication are all off.
- R7: If `txd_in` is low when the filtered enable falls in normal mode, the mode becomes fail-safe instead of sleep.
- R8: `supply_low` in normal mode forces fail-safe mode on the next clock. While `supply_low` is high, fail-safe mode does not move to normal.
- R9: A `wake_pulse` in sleep mode gives fail-safe mode on the next clock. Inhibit and termination come back on and `rxd_wake_low` is 1. `txd_strong_pd` equals `wake_is_local` as sampled with the pulse.
- R10: Both wake reports clear on the clock edge that samples `en_pin` high, before the enable filter completes.
- R11: A `wake_pulse` outside sleep mode changes neither the mode nor the wake reports.
- R12: `supply_good` going low in any mode gives off mode on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| supply_good | input | 1 | Supply above the power-up threshold |
| supply_low | input | 1 | Supply undervoltage flag (hysteresis applied upstream) |
| en_pin | input | 1 | Raw enable pin level |
| txd_in | input | 1 | Transmit data pin level |
| wake_pulse | input | 1 | One-cycle wake event from the wake detector |
| wake_is_local | input | 1 | Source of the wake event: 1 local switch, 0 bus |
| mode | output | 2 | 00 off, 01 fail-safe, 10 normal, 11 sleep |
| inh_on | output | 1 | Regulator enable switch |
| term_on | output | 1 | Bus termination enable |
| comm_on | output | 1 | Transmit/receive path enable |
| rxd_wake_low | output | 1 | Forces receive pin low to flag a wake request |
| txd_strong_pd | output | 1 | Strong pull-down on transmit pin for a local wake |

## Verification
The bench builds the block with `EN_ON_US=3`, `EN_OFF_US=5` and `PWRUP_US=4`. With these values every filter window and the power-up window fit in a few tick pulses. The bench drives the tick itself, so it knows the exact clock in which each transition is due. It sweeps every early-abort point of both enable filters to exercise the restart rule, and it covers both wake sources and both transmit levels at sleep entry.

// File: rtl/xmc_pkg.sv
package xmc_pkg;
   typedef enum logic [1:0] {
      MD_OFF      = 2'b00,
      MD_FAILSAFE = 2'b01,
      MD_NORMAL   = 2'b10,
      MD_SLEEP    = 2'b11
   } xmc_mode_e;

   function automatic int cnt_bits(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/xmc_en_filter.sv
module xmc_en_filter #(
   parameter int RISE_US = 7,
   parameter int FALL_US = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic raw,
   output logic filt
);
   localparam int MAXD = (RISE_US > FALL_US) ? RISE_US : FALL_US;
   localparam int CW   = xmc_pkg::cnt_bits(MAXD);

   if (RISE_US < 1) begin : g_bad_rise
      $error("RISE_US must be at least 1");
   end
   if (FALL_US < 1) begin : g_bad_fall
      $error("FALL_US must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] last_cnt;

   assign last_cnt = raw ? CW'(RISE_US - 1) : CW'(FALL_US - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt  <= 1'b0;
         cnt_q <= '0;
      end else if (raw == filt) begin
         cnt_q <= '0;
      end else if (tick) begin
         if (cnt_q == last_cnt) begin
            filt  <= raw;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R5
   filt_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(filt) |-> $past(tick) && ($past(raw) == filt));
endmodule

// File: rtl/xmc_pwrup_timer.sv
module xmc_pwrup_timer #(
   parameter int DELAY_US = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run,
   input  logic clear,
   output logic ready
);
   if (DELAY_US < 0) begin : g_bad_delay
      $error("DELAY_US must not be negative");
   end

   if (DELAY_US == 0) begin : g_nodelay
      logic live_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     live_q <= 1'b0;
         else if (clear) live_q <= 1'b0;
         else            live_q <= 1'b1;
      end
      assign ready = live_q;
   end else begin : g_count
      localparam int CW = xmc_pkg::cnt_bits(DELAY_US);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (clear)
            cnt_q <= '0;
         else if (run && tick && cnt_q != CW'(DELAY_US))
            cnt_q <= cnt_q + 1'b1;
      end
      assign ready = (cnt_q == CW'(DELAY_US));

      // R3
      ready_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ready) |-> $past(tick) && $past(run));
   end
endmodule

// File: rtl/xmc_mode_ctrl.sv
module xmc_mode_ctrl
   import xmc_pkg::*;
#(
   parameter int EN_ON_US  = 7,
   parameter int EN_OFF_US = 15,
   parameter int PWRUP_US  = 200
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_us,
   input  logic       supply_good,
   input  logic       supply_low,
   input  logic       en_pin,
   input  logic       txd_in,
   input  logic       wake_pulse,
   input  logic       wake_is_local,
   output logic [1:0] mode,
   output logic       inh_on,
   output logic       term_on,
   output logic       comm_on,
   output logic       rxd_wake_low,
   output logic       txd_strong_pd
);
   xmc_mode_e state_q, state_d;
   logic      en_filt, en_filt_q, en_fall;
   logic      wreq_q, wloc_q;
   logic      pwr_ready;
   logic      powered;

   xmc_en_filter #(.RISE_US(EN_ON_US), .FALL_US(EN_OFF_US)) u_en_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick_us),
      .raw  (en_pin),
      .filt (en_filt)
   );

   assign powered = (state_q == MD_FAILSAFE) || (state_q == MD_NORMAL);

   xmc_pwrup_timer #(.DELAY_US(PWRUP_US)) u_pwrup (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick_us),
      .run  (!supply_low),
      .clear(state_q == MD_OFF),
      .ready(pwr_ready)
   );

   assign en_fall = en_filt_q && !en_filt;

   always_comb begin
      state_d = state_q;
      if (!supply_good) begin
         state_d = MD_OFF;
      end else begin
         unique case (state_q)
            MD_OFF:      state_d = MD_FAILSAFE;
            MD_FAILSAFE: if (en_filt && !supply_low) state_d = MD_NORMAL;
            MD_NORMAL: begin
               if (supply_low)   state_d = MD_FAILSAFE;
               else if (en_fall) state_d = txd_in ? MD_SLEEP : MD_FAILSAFE;
            end
            MD_SLEEP:    if (wake_pulse) state_d = MD_FAILSAFE;
            default:     state_d = MD_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= MD_OFF;
         en_filt_q <= 1'b0;
         wreq_q    <= 1'b0;
         wloc_q    <= 1'b0;
      end else begin
         state_q   <= state_d;
         en_filt_q <= en_filt;
         if (!supply_good || en_pin) begin
            wreq_q <= 1'b0;
            wloc_q <= 1'b0;
         end else if (state_q == MD_SLEEP && wake_pulse) begin
            wreq_q <= 1'b1;
            wloc_q <= wake_is_local;
         end
      end
   end

   assign mode          = state_q;
   assign term_on       = powered;
   assign comm_on       = (state_q == MD_NORMAL);
   assign inh_on        = powered && pwr_ready && !supply_low;
   assign rxd_wake_low  = wreq_q && (state_q == MD_FAILSAFE);
   assign txd_strong_pd = wreq_q && wloc_q && (state_q == MD_FAILSAFE);

   // R12
   off_on_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_good |=> mode == 2'b00);
   // R4
   normal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MD_NORMAL && $past(state_q) == MD_FAILSAFE) |->
         $past(en_filt) && !$past(supply_low));
   // R6
   sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MD_SLEEP && $past(state_q) != MD_SLEEP) |->
         $past(txd_in) && $past(state_q) == MD_NORMAL);
   // R8
   uv_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_low && state_q == MD_NORMAL) |=> state_q != MD_NORMAL);
   // R9
   wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MD_FAILSAFE && $past(state_q) == MD_SLEEP) |-> $past(wake_pulse));
   // R10
   report_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en_pin) |-> !rxd_wake_low && !txd_strong_pd);
endmodule

// File: tb/xmc_mode_ctrl_tb.sv
module xmc_mode_ctrl_tb_top;
   localparam int CLK_P  = 10;
   localparam int ON_US  = 3;
   localparam int OFF_US = 5;
   localparam int PWR_US = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_us = 1'b0, supply_good = 1'b0, supply_low = 1'b0;
   logic en_pin = 1'b0, txd_in = 1'b1, wake_pulse = 1'b0, wake_is_local = 1'b0;
   logic [1:0] mode;
   logic inh_on, term_on, comm_on, rxd_wake_low, txd_strong_pd;
   int n_vec = 0, n_bad = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   xmc_mode_ctrl #(.EN_ON_US(ON_US), .EN_OFF_US(OFF_US), .PWRUP_US(PWR_US)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .supply_good(supply_good),
      .supply_low(supply_low), .en_pin(en_pin), .txd_in(txd_in),
      .wake_pulse(wake_pulse), .wake_is_local(wake_is_local), .mode(mode),
      .inh_on(inh_on), .term_on(term_on), .comm_on(comm_on),
      .rxd_wake_low(rxd_wake_low), .txd_strong_pd(txd_strong_pd));

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         tick_us = 1'b1;
         step();
         tick_us = 1'b0;
         step(3);
      end
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // packs {inh, term, comm, rxd_wake_low, txd_strong_pd}
   function automatic int outs();
      return {inh_on, term_on, comm_on, rxd_wake_low, txd_strong_pd};
   endfunction

   task automatic to_normal();
      en_pin = 1'b1;
      tick(ON_US);
   endtask

   task automatic to_sleep();
      txd_in = 1'b1;
      en_pin = 1'b0;
      tick(OFF_US);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(2);
      // R1: off state
      chk("R1 mode", mode, 0);
      chk("R1 outputs", outs(), 0);
      tick(2);
      chk("R1 still off", mode, 0);

      // R2: power-up
      supply_good = 1'b1;
      step();
      chk("R2 mode", mode, 1);
      chk("R2 outputs", outs(), 5'b01000);

      // R3: inhibit after PWR_US ticks
      for (int k = 1; k <= PWR_US; k++) begin
         tick();
         chk("R3 inh window", inh_on, (k >= PWR_US) ? 1 : 0);
      end

      // R5: rising filter restart at every early-abort point
      for (int k = 1; k < ON_US; k++) begin
         en_pin = 1'b1;
         tick(k);
         en_pin = 1'b0;
         step();
         en_pin = 1'b1;
         tick(ON_US - 1);
         chk("R5 rise restart", mode, 1);
         en_pin = 1'b0;
         step();
      end

      // R4
      to_normal();
      chk("R4 mode", mode, 2);
      chk("R4 outputs", outs(), 5'b11100);

      // R11: wake outside sleep
      wake_is_local = 1'b1;
      wake_pulse = 1'b1;
      step();
      wake_pulse = 1'b0;
      step();
      chk("R11 mode", mode, 2);
      chk("R11 reports", outs(), 5'b11100);

      // R5: falling filter restart at every early-abort point
      txd_in = 1'b1;
      for (int k = 1; k < OFF_US; k++) begin
         en_pin = 1'b0;
         tick(k);
         en_pin = 1'b1;
         step();
         en_pin = 1'b0;
         tick(OFF_US - 1);
         chk("R5 fall restart", mode, 2);
         en_pin = 1'b1;
         step();
      end

      // R6
      en_pin = 1'b0;
      tick(OFF_US);
      chk("R6 mode", mode, 3);
      chk("R6 outputs", outs(), 0);

      // R9 local wake
      wake_is_local = 1'b1;
      wake_pulse = 1'b1;
      step();
      wake_pulse = 1'b0;
      wake_is_local = 1'b0;
      chk("R9 local mode", mode, 1);
      chk("R9 local outputs", outs(), 5'b11011);

      // R10: clear on raw enable
      en_pin = 1'b1;
      step();
      chk("R10 mode", mode, 1);
      chk("R10 reports", outs(), 5'b11000);
      tick(ON_US);
      chk("R4 re-entry", mode, 2);

      // R7
      txd_in = 1'b0;
      en_pin = 1'b0;
      tick(OFF_US);
      chk("R7 mode", mode, 1);
      chk("R7 outputs", outs(), 5'b11000);

      // R9 remote wake
      to_normal();
      to_sleep();
      chk("R6 second sleep", mode, 3);
      wake_is_local = 1'b0;
      wake_pulse = 1'b1;
      step();
      wake_pulse = 1'b0;
      chk("R9 remote mode", mode, 1);
      chk("R9 remote outputs", outs(), 5'b11010);

      // R8
      to_normal();
      chk("R8 pre", mode, 2);
      supply_low = 1'b1;
      step();
      chk("R8 forced", mode, 1);
      chk("R8 outputs", outs(), 5'b01000);
      tick(ON_US + 1);
      chk("R8 held", mode, 1);
      supply_low = 1'b0;
      step();
      chk("R8 release", mode, 2);
      chk("R3 inh after uv", inh_on, 1);

      // R12
      supply_good = 1'b0;
      step();
      chk("R12 mode", mode, 0);
      chk("R12 outputs", outs(), 0);
      supply_good = 1'b1;
      step();
      chk("R3 inh restart", inh_on, 0);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         #(CLK_P * 200000) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule